// File: doc/BRIEF.md
# Serial Peripheral Interface Controller

This block is a register-mapped SPI port that moves 8-bit frames. Either it drives the serial clock itself as master, or it follows an external clock as slave. Software sets it up through a small byte-wide register window. The control register selects:

- the role (master or slave),
- the idle level of the clock,
- the edge on which data is captured,
- the bit order,
- whether completion and fault events raise the interrupt line.

In master mode, writing a byte to the data register starts a frame at once. The clock period comes from a divider register. In slave mode, the same written byte is shifted out on MISO during the next frame that an external master runs. In both roles, the byte most recently received is read back from the data register.

A master that sees its select input pulled active by another device reports a mode fault and steps down to slave mode. Completion and fault both set an interrupt flag that software clears by writing a one.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, every register reads 0, SCK rests low and the interrupt output is low.
- R2: The control register is at offset 0x00. Its fields are:
  - bit 3 (capture phase): 0 captures on the leading edge, 1 on the trailing edge;
  - bit 4 (clock idle level);
  - bit 5 (master role);
  - bit 6 (LSB first);
  - bit 7 (interrupt enable);
  - bits 2:0 always read 0.
- R3: In master mode, writing the data register (0x08) while idle produces 16 SCK transitions. The first comes H clock cycles after the write and each later one H cycles after the previous. SCK then rests at the bit-4 level. H is half of the divider register (0x0C), with that register taken as at least 8 and with its LSB cleared.
- R4: The master presents transmit bits on MOSI in the selected bit order. With capture phase 0 the first bit is present from the start and changes after each trailing edge. With capture phase 1 it changes after each leading edge but the first.
- R5: The master captures MISO on each capture edge. The assembled byte is readable at 0x08 after the frame.
- R6: Slave, capture phase 0: a frame starts when the active-low select falls, with the first transmit bit on MISO at once. Bits are captured on leading edges. Completion is flagged only when select rises after 8 captured bits.
- R7: Slave, capture phase 1: a frame starts at the first leading SCK edge while select is low. Bits are captured on trailing edges. Completion is flagged at the 8th capture, while select is still low.
- R8: Status (0x04) bit 7 is the completion flag. It is cleared only when a status read is immediately followed by a data-register access. A data access without a status read just before it leaves the flag set.
- R9: While in master mode, a low level on the select input sets status bit 4 (mode fault), clears control bit 5 and returns SCK to its idle level.
- R10: The mode-fault flag is cleared only when a status read is immediately followed by a control-register write.
- R11: Register 0x1C bit 0 is set whenever completion or mode fault is flagged. Writing 1 to it clears it and writing 0 has no effect. The interrupt output is that bit ANDed with control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Single-cycle register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock from an external master (slave role) |
| sck_o | output | 1 | Serial clock generated in master role |
| mosi_i | input | 1 | Serial data in (slave role) |
| mosi_o | output | 1 | Serial data out (master role) |
| miso_i | input | 1 | Serial data in (master role) |
| miso_o | output | 1 | Serial data out (slave role) |
| ssel_n_i | input | 1 | Active-low select input |
| irq_o | output | 1 | Interrupt request |

## Verification
The master path is exercised with all four combinations of clock level and capture phase and with both bit orders. It runs at divider settings below the minimum, odd and even. A model that tracks every clock cycle separates a wrong half-period, a missing or extra edge, and a bit presented or captured one edge early or late.

Transmit and receive bytes are asymmetric, so a reversed bit order cannot pass unseen. The slave runs with both capture phases. The select is held low past the 8th bit, which separates the select-delimited frame from the edge-delimited one.

The fault and flag-clearing sequences are each tried with and without the preceding status read, so a flag that clears too readily is caught.

// File: rtl/spi_pkg.sv
package spi_pkg;
    // Register offsets within the window
    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_DATA = 5'h08;
    localparam logic [4:0] OFS_DIV  = 5'h0C;
    localparam logic [4:0] OFS_INT  = 5'h1C;

    // Control fields, packed so that ctrl[7:3] maps member by member
    typedef struct packed {
        logic irq_en;    // bit 7
        logic lsb_first; // bit 6
        logic master;    // bit 5
        logic idle_hi;   // bit 4
        logic late_cap;  // bit 3
    } spi_cfg_t;

    localparam int MIN_PERIOD = 8;
endpackage

// File: rtl/spi_mst_eng.sv
module spi_mst_eng #(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               abort_i,
    input  logic               start_i,
    input  logic               idle_hi_i,
    input  logic               late_cap_i,
    input  logic               lsb_first_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [FRAME_W-1:0] tx_i,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rx_o
);
    import spi_pkg::*;

    localparam int EDGES = 2 * FRAME_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    logic [DIV_W-1:0]   period, half, cnt;
    logic [EW-1:0]      ecnt;
    logic               phase, edge_now, cap_edge, shf_edge;
    logic [FRAME_W-1:0] tsh, rsh;

    always_comb begin
        period   = (div_i < DIV_W'(MIN_PERIOD)) ? DIV_W'(MIN_PERIOD) : {div_i[DIV_W-1:1], 1'b0};
        half     = period >> 1;
        edge_now = busy_o && (cnt == half - 1'b1);
        cap_edge = (ecnt[0] == late_cap_i);
        shf_edge = !cap_edge && (ecnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
            ecnt   <= '0;
            if (rst) begin
                tsh <= '0;
                rsh <= '0;
            end
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                busy_o <= 1'b1;
                cnt    <= '0;
                ecnt   <= '0;
                phase  <= 1'b0;
                tsh    <= tx_i;
            end else if (edge_now) begin
                cnt   <= '0;
                phase <= ~phase;
                ecnt  <= ecnt + 1'b1;
                if (cap_edge)
                    rsh <= lsb_first_i ? {miso_i, rsh[FRAME_W-1:1]} : {rsh[FRAME_W-2:0], miso_i};
                if (shf_edge)
                    tsh <= lsb_first_i ? {1'b0, tsh[FRAME_W-1:1]} : {tsh[FRAME_W-2:0], 1'b0};
                if (ecnt == LAST_EDGE) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sck_o  = idle_hi_i ^ phase;
    assign mosi_o = lsb_first_i ? tsh[0] : tsh[FRAME_W-1];
    assign rx_o   = rsh;

    // R3
    sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !edge_now && !abort_i) |=> $stable(phase));
    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: rtl/spi_slv_eng.sv
module spi_slv_eng #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               idle_hi_i,
    input  logic               late_cap_i,
    input  logic               lsb_first_i,
    input  logic               sck_i,
    input  logic               mosi_i,
    input  logic               ssel_n_i,
    input  logic [FRAME_W-1:0] tx_i,
    output logic               miso_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rx_o
);
    localparam int BW = $clog2(FRAME_W + 1);
    localparam logic [BW-1:0] FULL = BW'(FRAME_W);
    localparam logic [BW-1:0] NEAR = BW'(FRAME_W - 1);

    logic               sck_q, ssel_q, in_frame;
    logic               lead, trail, sel_fall, sel_rise, cap, shf;
    logic [BW-1:0]      bcnt;
    logic [FRAME_W-1:0] tsh, rsh, rsh_nx, tsh_nx;

    always_comb begin
        lead     = (sck_i ^ idle_hi_i) && !(sck_q ^ idle_hi_i);
        trail    = !(sck_i ^ idle_hi_i) && (sck_q ^ idle_hi_i);
        sel_fall = !ssel_n_i && ssel_q;
        sel_rise = ssel_n_i && !ssel_q;
        cap      = late_cap_i ? trail : lead;
        shf      = late_cap_i ? lead : trail;
        rsh_nx   = lsb_first_i ? {mosi_i, rsh[FRAME_W-1:1]} : {rsh[FRAME_W-2:0], mosi_i};
        tsh_nx   = lsb_first_i ? {1'b0, tsh[FRAME_W-1:1]} : {tsh[FRAME_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            ssel_q   <= 1'b1;
            in_frame <= 1'b0;
            done_o   <= 1'b0;
            bcnt     <= '0;
            tsh      <= '0;
            rsh      <= '0;
        end else begin
            sck_q  <= sck_i;
            ssel_q <= ssel_n_i;
            done_o <= 1'b0;
            if (!en_i) begin
                in_frame <= 1'b0;
            end else if (!late_cap_i) begin
                if (sel_fall) begin
                    in_frame <= 1'b1;
                    bcnt     <= '0;
                    tsh      <= tx_i;
                end else if (sel_rise) begin
                    in_frame <= 1'b0;
                    if (in_frame && bcnt == FULL) done_o <= 1'b1;
                end else if (in_frame) begin
                    if (cap && bcnt != FULL) begin
                        rsh  <= rsh_nx;
                        bcnt <= bcnt + 1'b1;
                    end
                    if (shf) tsh <= tsh_nx;
                end
            end else begin
                if (ssel_n_i) begin
                    in_frame <= 1'b0;
                end else if (lead && !in_frame) begin
                    in_frame <= 1'b1;
                    bcnt     <= '0;
                    tsh      <= tx_i;
                end else if (in_frame) begin
                    if (shf) tsh <= tsh_nx;
                    if (cap) begin
                        rsh  <= rsh_nx;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == NEAR) begin
                            done_o   <= 1'b1;
                            in_frame <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign miso_o = lsb_first_i ? tsh[0] : tsh[FRAME_W-1];
    assign rx_o   = rsh;

    // R7
    slv_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !in_frame);
    // R6
    slv_count_chk: assert property (@(posedge clk) disable iff (rst)
        in_frame |-> (bcnt <= FULL));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sck_i,
    output logic       sck_o,
    input  logic       mosi_i,
    output logic       mosi_o,
    input  logic       miso_i,
    output logic       miso_o,
    input  logic       ssel_n_i,
    output logic       irq_o
);
    import spi_pkg::*;

    spi_cfg_t           cfg;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] tx_q, rx_q, m_rx, s_rx;
    logic               spif, modf, intf, stat_seen;
    logic               wr_ctrl, wr_data, wr_div, wr_int, rd_stat, rd_data;
    logic               m_busy, m_done, s_done, done_any, fault;

    always_comb begin
        wr_ctrl  = bus_wr && bus_addr == OFS_CTRL;
        wr_data  = bus_wr && bus_addr == OFS_DATA;
        wr_div   = bus_wr && bus_addr == OFS_DIV;
        wr_int   = bus_wr && bus_addr == OFS_INT;
        rd_stat  = bus_rd && bus_addr == OFS_STAT;
        rd_data  = bus_rd && bus_addr == OFS_DATA;
        done_any = m_done || s_done;
        fault    = cfg.master && !ssel_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            div_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            spif      <= 1'b0;
            modf      <= 1'b0;
            intf      <= 1'b0;
            stat_seen <= 1'b0;
        end else begin
            if (wr_ctrl) cfg   <= spi_cfg_t'(bus_wdata[7:3]);
            if (wr_div)  div_q <= bus_wdata[DIV_W-1:0];
            if (wr_data) tx_q  <= bus_wdata[FRAME_W-1:0];
            if (rd_stat)                 stat_seen <= 1'b1;
            else if (bus_wr || bus_rd)   stat_seen <= 1'b0;
            if (stat_seen && (rd_data || wr_data)) spif <= 1'b0;
            if (stat_seen && wr_ctrl)              modf <= 1'b0;
            if (wr_int && bus_wdata[0])            intf <= 1'b0;
            if (done_any) begin
                spif <= 1'b1;
                rx_q <= m_done ? m_rx : s_rx;
            end
            if (fault) begin
                modf       <= 1'b1;
                cfg.master <= 1'b0;
            end
            if (done_any || fault) intf <= 1'b1;
        end
    end

    spi_mst_eng #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) mst_i (
        .clk(clk), .rst(rst), .abort_i(fault), .start_i(wr_data && cfg.master),
        .idle_hi_i(cfg.idle_hi), .late_cap_i(cfg.late_cap), .lsb_first_i(cfg.lsb_first),
        .div_i(div_q), .tx_i(bus_wdata[FRAME_W-1:0]), .miso_i(miso_i),
        .sck_o(sck_o), .mosi_o(mosi_o), .busy_o(m_busy), .done_o(m_done), .rx_o(m_rx)
    );

    spi_slv_eng #(.FRAME_W(FRAME_W)) slv_i (
        .clk(clk), .rst(rst), .en_i(!cfg.master),
        .idle_hi_i(cfg.idle_hi), .late_cap_i(cfg.late_cap), .lsb_first_i(cfg.lsb_first),
        .sck_i(sck_i), .mosi_i(mosi_i), .ssel_n_i(ssel_n_i), .tx_i(tx_q),
        .miso_o(miso_o), .done_o(s_done), .rx_o(s_rx)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {cfg, 3'b000};
            OFS_STAT: bus_rdata = {spif, 2'b00, modf, 4'b0000};
            OFS_DATA: bus_rdata = 8'(rx_q);
            OFS_DIV:  bus_rdata = 8'(div_q);
            OFS_INT:  bus_rdata = {7'b0, intf};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = intf && cfg.irq_en;

    // R9
    mode_fault_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!cfg.master && modf && !m_busy));
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spif) |-> $past(stat_seen));
    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (done_any && cfg.irq_en && !wr_ctrl) |=> irq_o);
endmodule

// File: tb/spi_ctrl_tb_top.sv
module spi_ctrl_tb_top;
    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ssel_n_i = 1'b1;
    logic       sck_o, mosi_o, miso_o, irq_o;

    always #4 clk = ~clk;

    spi_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o),
        .ssel_n_i(ssel_n_i), .irq_o(irq_o)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural master model: counts cycles since the starting write
    bit         m_master = 0, m_cpol = 0, m_cpha = 0, m_lsbf = 0, m_run = 0;
    int         m_half = 4, m_n = 0;
    logic [7:0] m_tx = '0, m_pat = '0;

    always @(posedge clk) begin
        if (m_run) begin
            m_n++;
            if (m_n > 16 * m_half) m_run = 0;
        end else if (!rst && bus_wr && bus_addr == 5'h08 && m_master) begin
            m_run = 1;
            m_n   = 0;
            m_tx  = bus_wdata;
        end
    end

    always @(negedge clk) begin
        if (m_run) begin
            int e, sh, smp;
            e = m_n / m_half;
            if (m_n < 16 * m_half) begin
                check("R3 sck level", sck_o, m_cpol ^ e[0]);
                sh = m_cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
                check("R4 mosi bit", mosi_o, m_tx[m_lsbf ? sh : 7 - sh]);
            end else begin
                check("R3 sck idle after frame", sck_o, m_cpol);
            end
            smp = m_cpha ? e / 2 : (e + 1) / 2;
            if (smp < 8) miso_i = m_pat[m_lsbf ? smp : 7 - smp];
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic mst_xfer(input logic [7:0] ctrl, input logic [7:0] div,
                            input logic [7:0] tx, input logic [7:0] pat);
        m_cpol = ctrl[4]; m_cpha = ctrl[3]; m_lsbf = ctrl[6];
        m_half = ((div < 8) ? 8 : int'(div & 8'hFE)) / 2;
        m_pat  = pat;
        wr(5'h0C, div);
        wr(5'h00, ctrl);
        m_master = 1;
        wr(5'h08, tx);
        for (int k = 0; k < 4000 && m_run; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        if (ctrl[7]) check("R11 irq after completion", irq_o, 1);
        rd_chk("R5 data held until status read", 5'h08, pat);
        rd_chk("R8 flag kept without status read", 5'h04, 8'h80);
        rd_chk("R5 received byte", 5'h08, pat);
        rd_chk("R8 flag cleared", 5'h04, 8'h00);
        if (ctrl[7]) begin
            rd_chk("R11 flag register set", 5'h1C, 8'h01);
            wr(5'h1C, 8'h01);
            check("R11 irq cleared by write 1", irq_o, 0);
        end
        m_master = 0;
    endtask

    task automatic slv_xfer(input logic [7:0] ctrl, input logic [7:0] txb, input logic [7:0] mb);
        bit cpol, lsbf;
        cpol = ctrl[4]; lsbf = ctrl[6];
        wr(5'h00, ctrl);
        wr(5'h08, txb);
        sck_i = cpol;
        repeat (3) @(negedge clk);
        ssel_n_i = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            int bi = lsbf ? i : 7 - i;
            if (!ctrl[3]) begin
                mosi_i = mb[bi];
                check("R6 slave miso bit", miso_o, txb[bi]);
                sck_i = ~cpol; repeat (3) @(negedge clk);
                sck_i = cpol;  repeat (3) @(negedge clk);
            end else begin
                sck_i = ~cpol; repeat (3) @(negedge clk);
                check("R7 slave miso bit", miso_o, txb[bi]);
                mosi_i = mb[bi];
                sck_i = cpol;  repeat (3) @(negedge clk);
            end
        end
        if (!ctrl[3]) begin
            rd_chk("R6 no completion while select low", 5'h04, 8'h00);
            ssel_n_i = 1'b1;
            repeat (3) @(negedge clk);
            rd_chk("R6 completion at select release", 5'h04, 8'h80);
            rd_chk("R6 slave received byte", 5'h08, mb);
        end else begin
            rd_chk("R7 completion before select release", 5'h04, 8'h80);
            rd_chk("R7 slave received byte", 5'h08, mb);
            ssel_n_i = 1'b1;
            repeat (3) @(negedge clk);
        end
        rd_chk("R8 slave flag cleared", 5'h04, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 control reset", 5'h00, 8'h00);
        rd_chk("R1 status reset", 5'h04, 8'h00);
        rd_chk("R1 data reset", 5'h08, 8'h00);
        rd_chk("R1 divider reset", 5'h0C, 8'h00);
        rd_chk("R1 int flag reset", 5'h1C, 8'h00);
        check("R1 sck idle low", sck_o, 0);
        check("R1 irq low", irq_o, 0);
        // R2 field layout
        wr(5'h00, 8'hDF);
        rd_chk("R2 reserved bits read zero", 5'h00, 8'hD8);
        wr(5'h00, 8'h30);
        check("R2 idle level high", sck_o, 1);
        wr(5'h00, 8'h20);
        check("R2 idle level low", sck_o, 0);
        // R3 R4 R5 master frames
        mst_xfer(8'h20, 8'h00, 8'hB1, 8'h6D);
        mst_xfer(8'h30, 8'h0D, 8'h1E, 8'hC4);
        mst_xfer(8'h28, 8'h09, 8'h93, 8'h27);
        mst_xfer(8'h78, 8'h14, 8'h4B, 8'hE2);
        mst_xfer(8'hE0, 8'h08, 8'h0F, 8'h58);
        // R6 R7 slave frames
        slv_xfer(8'h00, 8'hA6, 8'h3C);
        slv_xfer(8'h50, 8'h71, 8'h8E);
        slv_xfer(8'h08, 8'h2D, 8'hB4);
        slv_xfer(8'h58, 8'hC9, 8'h16);
        // R9 mode fault
        wr(5'h00, 8'hB0);
        ssel_n_i = 1'b0;
        repeat (2) @(negedge clk);
        ssel_n_i = 1'b1;
        rd_chk("R9 master bit cleared", 5'h00, 8'h90);
        check("R9 sck at idle level", sck_o, 1);
        check("R11 irq on fault", irq_o, 1);
        // R10 clearing rules
        wr(5'h00, 8'h90);
        rd_chk("R10 fault kept without status read", 5'h04, 8'h10);
        wr(5'h00, 8'h90);
        rd_chk("R10 fault cleared", 5'h04, 8'h00);
        // R11 write 0 ignored, write 1 clears
        wr(5'h1C, 8'h00);
        check("R11 write 0 keeps irq", irq_o, 1);
        wr(5'h1C, 8'h01);
        check("R11 write 1 clears irq", irq_o, 0);
        rd_chk("R11 flag register cleared", 5'h1C, 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule